// File: doc/BRIEF.md
# JTAG Debug-Port Access Sequencer

This block carries out one debug-port register access, either a read or a write, through a JTAG scan chain that may contain several devices. Each access is offered as a single request. The request carries the direction bit, two address bits, 32 bits of write data, a flag that enables acknowledge checking, the position of the target in the chain, the number of devices in the chain and a count of idle clocks. The block starts from Run-Test/Idle and walks the TAP through a DR scan. It shifts out the request bits and collects the 3-bit acknowledge. It then moves the data word and steps through the bypass bits of the devices that follow the target. It finishes by returning the TAP to Run-Test/Idle.

The bypass bits of the devices ahead of the target are absorbed by the TMS-low clocks that move the TAP into Shift-DR. The bypass bits of the devices behind the target are absorbed after the data word. The acknowledge seen on the wire is translated into a debug-port style code before it is returned.

TCK timing comes from a single-cycle `tick` enable, which is produced outside the block. Requests enter and responses leave through valid/ready handshakes. `req_ready` is high only when the block is idle and has no response waiting. Once `rsp_valid` rises, the response fields stay fixed until `rsp_ready` is seen, and no new request is taken before then.

Top module: `dp_scan_xfer`

## Requirements
- R1: A request is accepted on a clock with `req_valid` and `req_ready` both high. `req_ready` is high only while no access is in progress and no response is pending. While `rsp_valid` is high and `rsp_ready` is low, `rsp_ack` and `rsp_rdata` do not change.
- R2: TCK rests high. Each scan bit uses two ticks. On the first tick TCK falls and TMS/TDI take their new values. On the second tick TCK rises and TDO is sampled. TCK changes only on a clock edge where `tick` was high, and TMS/TDI do not change across a rising TCK.
- R3: An access opens with one bit at TMS=1, followed by `chain_pos`+2 bits at TMS=0. TDI is 1 for all of these bits.
- R4: Three request bits are then shifted at TMS=0 in this order: `req_rnw`, `req_addr[0]`, `req_addr[1]`. The three TDO samples taken during these bits form the raw acknowledge, with the first sample as bit 0.
- R5: A raw acknowledge of 3'b010 is translated to code 1 (OK). A raw acknowledge of 3'b001 is translated to code 2 (WAIT). Every other raw value is returned unchanged.
- R6: When `req_check` is 1 and the translated code is not 1, the block sends one bit at TMS=1 with TDI=1. The data phase is skipped and `rsp_rdata` is 0.
- R7: Otherwise the data phase starts with 31 bits at TMS=0, LSB first. TDI carries `req_wdata` on writes and is 1 on reads. On reads, the 32 TDO samples form `rsp_rdata`, LSB first.
- R8: When the target is the last device (`chain_pos` = `chain_len`-1), the 32nd data bit is sent at TMS=1.
- R9: When F = `chain_len`-`chain_pos`-1 is greater than 0, the 32nd data bit is sent at TMS=0. It is followed by F-1 bits at TMS=0 and then one bit at TMS=1. All of these follower bits carry TDI=1.
- R10: Every access then sends one bit at TMS=1 and one bit at TMS=0, both with TDI=1. After the last clock, TDI stays at 1 and TMS stays at 0.
- R11: When `req_check` is 1, `idle_cnt` more bits follow at TMS=0 with TDI=1. When `req_check` is 0, no such bits are sent and `rsp_ack` is 1.
- R12: For a write, `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable that advances the TCK phase |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Register address bits (bit 0 is sent first) |
| req_wdata | input | DW | Write data |
| req_check | input | 1 | Enables acknowledge checking and the idle clocks |
| chain_pos | input | POS_W | Index of the target device in the chain |
| chain_len | input | POS_W+1 | Number of devices in the chain |
| idle_cnt | input | IDLE_W | Number of idle clocks after a checked access |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_ack | output | 3 | Translated acknowledge code |
| rsp_rdata | output | DW | Read data |
| tck | output | 1 | JTAG clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to the chain |
| tdo | input | 1 | JTAG data from the chain |

## Verification
The paths that are hardest to reach from the ports are the abort path and the case with exactly one follower device. The abort path depends on the three TDO values sampled during the request bits. The one-follower case has a follower segment of zero length. For each access the bench builds a list of the expected bits, and each entry also records the TDO level to present when TCK falls. This lets the captured acknowledge be set to OK, WAIT, or an unmapped pattern at will, both with checking on and with checking off. The bench also uses a chain length of exactly `chain_pos`+2 and runs the sequences at several tick rates.

// File: rtl/dpsx_pkg.sv
package dpsx_pkg;

  typedef enum logic [3:0] {
    SEG_IDLE,
    SEG_SEL,
    SEG_SKIP,
    SEG_REQ,
    SEG_ABORT,
    SEG_DATA,
    SEG_LAST,
    SEG_POST,
    SEG_EXIT,
    SEG_UPD,
    SEG_RTI,
    SEG_IDLECLK,
    SEG_RESP
  } seg_e;

  localparam logic [2:0] CODE_OK   = 3'd1;
  localparam logic [2:0] CODE_WAIT = 3'd2;
  localparam logic [2:0] WIRE_OK   = 3'b010;
  localparam logic [2:0] WIRE_WAIT = 3'b001;

endpackage

// File: rtl/dpsx_tck_gen.sv
module dpsx_tck_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic tck,
  output logic lo_stb,
  output logic hi_stb
);

  logic phase;

  assign lo_stb = run & tick & ~phase;
  assign hi_stb = run & tick & phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      tck   <= 1'b1;
    end else if (lo_stb) begin
      phase <= 1'b1;
      tck   <= 1'b0;
    end else if (hi_stb) begin
      phase <= 1'b0;
      tck   <= 1'b1;
    end
  end

  // R2
  tck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tck) |-> $past(tick));

endmodule

// File: rtl/dpsx_ack_map.sv
module dpsx_ack_map
  import dpsx_pkg::*;
(
  input  logic [2:0] wire_ack,
  output logic [2:0] code
);

  always_comb begin
    unique case (wire_ack)
      WIRE_OK:   code = CODE_OK;
      WIRE_WAIT: code = CODE_WAIT;
      default:   code = wire_ack;
    endcase
  end

endmodule

// File: rtl/dpsx_seq.sv
module dpsx_seq
  import dpsx_pkg::*;
#(
  parameter int DW     = 32,
  parameter int POS_W  = 4,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rnw,
  input  logic [1:0]        req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              req_check,
  input  logic [POS_W-1:0]  chain_pos,
  input  logic [POS_W:0]    chain_len,
  input  logic [IDLE_W-1:0] idle_cnt,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_ack,
  output logic [DW-1:0]     rsp_rdata,
  input  logic              lo_stb,
  input  logic              hi_stb,
  output logic              run,
  input  logic              tdo,
  output logic              tms,
  output logic              tdi,
  output logic [2:0]        wire_ack,
  input  logic [2:0]        ack_code
);

  localparam int DW_BITS  = $clog2(DW) + 1;
  localparam int MAX_A    = (DW_BITS > POS_W + 2) ? DW_BITS : POS_W + 2;
  localparam int CNT_W    = (MAX_A > IDLE_W + 1) ? MAX_A : IDLE_W + 1;

  seg_e               seg, seg_nx;
  logic [CNT_W-1:0]   cnt, cnt_nx;
  logic               rnw_q, check_q;
  logic [POS_W-1:0]   pos_q;
  logic [POS_W:0]     after_q;
  logic [IDLE_W-1:0]  idle_q;
  logic [2:0]         req_sh, ack_sh, ack_q;
  logic [DW-1:0]      wr_sh, rd_sh;
  logic               last_bit, tms_bit, tdi_bit;

  assign req_ready = (seg == SEG_IDLE);
  assign rsp_valid = (seg == SEG_RESP);
  assign rsp_ack   = ack_q;
  assign rsp_rdata = rd_sh;
  assign run       = (seg != SEG_IDLE) && (seg != SEG_RESP);
  assign last_bit  = (cnt == CNT_W'(1));
  assign wire_ack  = {tdo, ack_sh[2:1]};

  // pin values for the bit of the current segment
  always_comb begin
    tms_bit = 1'b0;
    tdi_bit = 1'b1;
    unique case (seg)
      SEG_SEL, SEG_ABORT, SEG_EXIT, SEG_UPD: tms_bit = 1'b1;
      SEG_REQ:  tdi_bit = req_sh[0];
      SEG_DATA: tdi_bit = wr_sh[0];
      SEG_LAST: begin
        tms_bit = (after_q == '0);
        tdi_bit = wr_sh[0];
      end
      default: ;
    endcase
  end

  // segment sequencing at the end of each bit
  always_comb begin
    seg_nx = seg;
    cnt_nx = cnt - CNT_W'(1);
    if (last_bit) begin
      cnt_nx = CNT_W'(1);
      unique case (seg)
        SEG_SEL: begin
          seg_nx = SEG_SKIP;
          cnt_nx = CNT_W'(pos_q) + CNT_W'(2);
        end
        SEG_SKIP: begin
          seg_nx = SEG_REQ;
          cnt_nx = CNT_W'(3);
        end
        SEG_REQ: begin
          if (check_q && (ack_code != CODE_OK)) begin
            seg_nx = SEG_ABORT;
          end else begin
            seg_nx = SEG_DATA;
            cnt_nx = CNT_W'(DW - 1);
          end
        end
        SEG_ABORT: seg_nx = SEG_UPD;
        SEG_DATA:  seg_nx = SEG_LAST;
        SEG_LAST: begin
          if (after_q == '0) begin
            seg_nx = SEG_UPD;
          end else if (after_q == (POS_W+1)'(1)) begin
            seg_nx = SEG_EXIT;
          end else begin
            seg_nx = SEG_POST;
            cnt_nx = CNT_W'(after_q) - CNT_W'(1);
          end
        end
        SEG_POST: seg_nx = SEG_EXIT;
        SEG_EXIT: seg_nx = SEG_UPD;
        SEG_UPD:  seg_nx = SEG_RTI;
        SEG_RTI: begin
          if (check_q && (idle_q != '0)) begin
            seg_nx = SEG_IDLECLK;
            cnt_nx = CNT_W'(idle_q);
          end else begin
            seg_nx = SEG_RESP;
          end
        end
        SEG_IDLECLK: seg_nx = SEG_RESP;
        default: seg_nx = seg;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg     <= SEG_IDLE;
      cnt     <= '0;
      rnw_q   <= 1'b0;
      check_q <= 1'b0;
      pos_q   <= '0;
      after_q <= '0;
      idle_q  <= '0;
      req_sh  <= '0;
      ack_sh  <= '0;
      ack_q   <= '0;
      wr_sh   <= '0;
      rd_sh   <= '0;
      tms     <= 1'b0;
      tdi     <= 1'b1;
    end else begin
      if (seg == SEG_IDLE && req_valid) begin
        seg     <= SEG_SEL;
        cnt     <= CNT_W'(1);
        rnw_q   <= req_rnw;
        check_q <= req_check;
        pos_q   <= chain_pos;
        after_q <= chain_len - (POS_W+1)'(chain_pos) - (POS_W+1)'(1);
        idle_q  <= idle_cnt;
        req_sh  <= {req_addr[1], req_addr[0], req_rnw};
        wr_sh   <= req_rnw ? '1 : req_wdata;
        rd_sh   <= '0;
        ack_sh  <= '0;
      end
      if (lo_stb) begin
        tms <= tms_bit;
        tdi <= tdi_bit;
      end
      if (hi_stb) begin
        if (seg == SEG_REQ) begin
          ack_sh <= wire_ack;
          req_sh <= {1'b1, req_sh[2:1]};
          if (last_bit) ack_q <= check_q ? ack_code : CODE_OK;
        end
        if (seg == SEG_DATA || seg == SEG_LAST) begin
          wr_sh <= {1'b1, wr_sh[DW-1:1]};
          if (rnw_q) rd_sh <= {tdo, rd_sh[DW-1:1]};
        end
        seg <= seg_nx;
        cnt <= cnt_nx;
        if (seg_nx == SEG_RESP) tdi <= 1'b1;
      end
      if (seg == SEG_RESP && rsp_ready) seg <= SEG_IDLE;
    end
  end

  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ack) && $stable(rsp_rdata));

  // R6
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_ABORT) |-> check_q && (ack_q != CODE_OK));

  // R10
  rest_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> tdi && !tms);

  // R11
  nocheck_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !check_q |-> rsp_ack == CODE_OK);

  // R12
  write_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rnw_q |-> rsp_rdata == '0);

endmodule

// File: rtl/dp_scan_xfer.sv
module dp_scan_xfer #(
  parameter int DW     = 32,
  parameter int POS_W  = 4,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rnw,
  input  logic [1:0]        req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              req_check,
  input  logic [POS_W-1:0]  chain_pos,
  input  logic [POS_W:0]    chain_len,
  input  logic [IDLE_W-1:0] idle_cnt,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_ack,
  output logic [DW-1:0]     rsp_rdata,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);

  logic       run, lo_stb, hi_stb;
  logic [2:0] wire_ack, ack_code;

  dpsx_tck_gen u_tck (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .run    (run),
    .tck    (tck),
    .lo_stb (lo_stb),
    .hi_stb (hi_stb)
  );

  dpsx_ack_map u_map (
    .wire_ack (wire_ack),
    .code     (ack_code)
  );

  dpsx_seq #(
    .DW     (DW),
    .POS_W  (POS_W),
    .IDLE_W (IDLE_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_rnw   (req_rnw),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_check (req_check),
    .chain_pos (chain_pos),
    .chain_len (chain_len),
    .idle_cnt  (idle_cnt),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_ack   (rsp_ack),
    .rsp_rdata (rsp_rdata),
    .lo_stb    (lo_stb),
    .hi_stb    (hi_stb),
    .run       (run),
    .tdo       (tdo),
    .tms       (tms),
    .tdi       (tdi),
    .wire_ack  (wire_ack),
    .ack_code  (ack_code)
  );

  // R2
  pins_steady_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> $stable(tms) && $stable(tdi));

  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && tck);

endmodule

// File: tb/dp_scan_xfer_tb_top.sv
`timescale 1ns/1ps
module dp_scan_xfer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_rnw = 1'b0;
  logic [1:0]  req_addr = 2'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        req_check = 1'b0;
  logic [3:0]  chain_pos = 4'd0;
  logic [4:0]  chain_len = 5'd1;
  logic [7:0]  idle_cnt = 8'd0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_rdata;
  logic        tck, tms, tdi;
  logic        tdo = 1'b0;

  int vec = 0;
  int bad = 0;
  bit    q_tms[$];
  bit    q_tdi[$];
  bit    q_tdo[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  dp_scan_xfer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_rnw(req_rnw),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_check(req_check),
    .chain_pos(chain_pos), .chain_len(chain_len), .idle_cnt(idle_cnt),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] map_ack(input logic [2:0] w);
    if (w == 3'b010) return 3'd1;
    if (w == 3'b001) return 3'd2;
    return w;
  endfunction

  task automatic push(input bit m, input bit d, input bit o, input string t);
    q_tms.push_back(m);
    q_tdi.push_back(d);
    q_tdo.push_back(o);
    q_tag.push_back(t);
  endtask

  task automatic do_access(input bit rnw, input logic [1:0] addr,
                           input logic [31:0] wd, input int pos, input int len,
                           input int idle, input bit check,
                           input logic [2:0] wack, input logic [31:0] rdpat,
                           input int div);
    logic [2:0]  exp_ack;
    logic [31:0] exp_rd;
    bit          abort;
    int          after;
    bit          prev_tck, prev_tick, fall_tms, fall_tdi, done;
    int          cyc;
    logic [2:0]  hold_ack;
    logic [31:0] hold_rd;

    exp_ack = check ? map_ack(wack) : 3'd1;
    abort   = check && (map_ack(wack) != 3'd1);
    exp_rd  = (rnw && !abort) ? rdpat : 32'd0;
    after   = len - pos - 1;

    push(1, 1, 0, "R3");
    for (int i = 0; i < pos + 2; i++) push(0, 1, 0, "R3");
    push(0, rnw, wack[0], "R4");
    push(0, addr[0], wack[1], "R4");
    push(0, addr[1], wack[2], "R4");
    if (abort) begin
      push(1, 1, 0, "R6");
    end else begin
      for (int i = 0; i < 31; i++) push(0, rnw ? 1'b1 : wd[i], rdpat[i], "R7");
      push(after == 0, rnw ? 1'b1 : wd[31], rdpat[31], after == 0 ? "R8" : "R9");
      if (after > 0) begin
        for (int i = 0; i < after - 1; i++) push(0, 1, 0, "R9");
        push(1, 1, 0, "R9");
      end
    end
    push(1, 1, 0, "R10");
    push(0, 1, 0, "R10");
    if (check) for (int i = 0; i < idle; i++) push(0, 1, 0, "R11");

    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_rnw   = rnw;
    req_addr  = addr;
    req_wdata = wd;
    req_check = check;
    chain_pos = 4'(pos);
    chain_len = 5'(len);
    idle_cnt  = 8'(idle);
    tick      = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 ready drops while busy", req_ready, 0);
    prev_tck  = 1'b1;
    prev_tick = 1'b0;
    fall_tms  = 1'b0;
    fall_tdi  = 1'b1;
    done      = 1'b0;
    cyc       = 0;
    while (!done) begin
      if ((tck != prev_tck) && !prev_tick)
        chk(0, "R2 tck moved without tick", tck, prev_tck);
      if (prev_tck && !tck) begin
        if (q_tms.size() == 0) begin
          chk(0, "R11 extra scan bit", 1, 0);
        end else begin
          string t;
          bit em, ed;
          em = q_tms.pop_front();
          ed = q_tdi.pop_front();
          t  = q_tag.pop_front();
          chk(tms == em, {t, " tms"}, tms, em);
          chk(tdi == ed, {t, " tdi"}, tdi, ed);
          tdo = q_tdo.pop_front();
        end
        fall_tms = tms;
        fall_tdi = tdi;
      end
      if (!prev_tck && tck)
        chk(tms == fall_tms && tdi == fall_tdi, "R2 pins move at rise",
            {tms, tdi}, {fall_tms, fall_tdi});
      if (rsp_valid) done = 1'b1;
      prev_tck  = tck;
      tick      = ((cyc % div) == div - 1);
      prev_tick = tick;
      cyc++;
      if (!done) @(negedge clk);
    end
    tick = 1'b0;
    chk(q_tms.size() == 0, "R11 scan bit count", q_tms.size(), 0);
    q_tms.delete(); q_tdi.delete(); q_tdo.delete(); q_tag.delete();
    chk(rsp_ack == exp_ack, "R5 ack code", rsp_ack, exp_ack);
    if (rnw) chk(rsp_rdata == exp_rd, "R7 read data", rsp_rdata, exp_rd);
    else     chk(rsp_rdata == 32'd0, "R12 write rdata", rsp_rdata, 0);
    chk(tdi == 1'b1 && tms == 1'b0 && tck == 1'b1, "R10 rest levels",
        {tck, tms, tdi}, 3'b101);
    hold_ack = rsp_ack;
    hold_rd  = rsp_rdata;
    @(negedge clk);
    @(negedge clk);
    chk(rsp_valid && rsp_ack == hold_ack && rsp_rdata == hold_rd && !req_ready,
        "R1 response held", {rsp_valid, rsp_ack}, {1'b1, hold_ack});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R1 response released", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 reset handshake",
        {req_ready, rsp_valid}, 2'b10);
    chk(tck == 1'b1 && tms == 1'b0 && tdi == 1'b1, "R2 reset pins",
        {tck, tms, tdi}, 3'b101);
    rst_n = 1'b1;
    @(negedge clk);
    // single device write, checked, OK, idle clocks
    do_access(0, 2'b01, 32'hA5C3_1E7F, 0, 1, 2, 1, 3'b010, 32'h0, 1);
    // read mid-chain with two followers
    do_access(1, 2'b10, 32'h0, 1, 4, 0, 1, 3'b010, 32'h8123_4567, 1);
    // exactly one follower
    do_access(1, 2'b11, 32'h0, 0, 2, 3, 1, 3'b010, 32'hF00D_0001, 2);
    // WAIT aborts
    do_access(1, 2'b00, 32'h0, 1, 3, 1, 1, 3'b001, 32'hFFFF_FFFF, 1);
    // unmapped pattern aborts, passed through
    do_access(0, 2'b10, 32'h1234_5678, 2, 3, 0, 1, 3'b111, 32'h0, 3);
    do_access(0, 2'b01, 32'h1234_5678, 0, 1, 1, 1, 3'b100, 32'h0, 1);
    // checking off: WAIT ignored, no idle clocks
    do_access(1, 2'b01, 32'h0, 2, 3, 5, 0, 3'b001, 32'h7654_3210, 1);
    // last device of a long chain, slow tick
    do_access(0, 2'b11, 32'h8000_0001, 15, 16, 4, 1, 3'b010, 32'h0, 3);
    // first device of a long chain
    do_access(1, 2'b00, 32'h0, 0, 16, 0, 0, 3'b110, 32'hDEAD_BEEF, 2);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule